// File: doc/BRIEF.md
# ECC Error Event Capture Unit

This unit sits beside a memory ECC checker on a 32-bit system bus and records what went wrong. The checker reports each error as a one-cycle pulse that carries the access address, the bus attributes of the access, the read data and a class bit. The class bit tells a corrected single-bit error apart from an uncorrectable one. A control register holds one enable bit per class. When an event of an enabled class arrives, the unit loads the address, attributes and data into capture registers in one clock edge. It also sets a sticky flag for that class.

Software reads the control register, the flags and the capture registers through a small word-indexed register port, and clears flags by writing ones. The capture registers always describe the most recent enabled event. The address is stored with its low bits forced to zero, so it names the aligned doubleword rather than the exact byte. The capture registers have no reset and hold unknown contents until the first enabled event.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset, the control register (index 0) and the flag register (index 1) read as zero.
- R2: An event whose class is disabled changes neither the flags nor any capture register.
- R3: An enabled event loads the attributes (index 3, zero-extended) and the data (index 4) from the same pulse as the address, visible in readback from the cycle after the pulse.
- R4: The captured address (index 2) equals the event address with bits 2:0 forced to zero.
- R5: An enabled event with class 0 (corrected) sets flag bit 0, and with class 1 (uncorrectable) sets flag bit 1. Control bit 0 enables class 0 and control bit 1 enables class 1.
- R6: Flags stay set until software writes index 1 with a 1 in that bit position. Writing 0 to a flag bit leaves it unchanged.
- R7: When an event sets a flag in the same cycle that a write clears that flag, the flag ends up set.
- R8: Each later enabled event overwrites all three capture registers, whatever flags are still set.
- R9: A write to index 0 stores bits 1:0 as the enables. An event in the same cycle as that write is judged with the previous enables.
- R10: Readback is combinational from the index. Indices 5 to 7 read zero, and writes to any index other than 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of control and flags |
| evt_valid | input | 1 | One-cycle error event pulse |
| evt_uncorr | input | 1 | Event class: 0 corrected single-bit, 1 uncorrectable |
| evt_addr | input | 32 | Bus address of the faulting access |
| evt_attr | input | 8 | Bus attributes of the access |
| evt_data | input | 32 | Data associated with the access |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |

## Verification
Directed sequences first send events of a disabled class, then events of each class alone, which separates the per-class enable decode from the flag encoding. Addresses with all low bits set show whether the alignment is applied. Flag clears that fall in the same cycle as a new event, and control writes that fall in the same cycle as an event, isolate the set-over-clear priority and the use of the old enables. A long pseudo-random run mixes both classes, enable changes, partial clears and writes to read-only or unmapped indices, and checks that the newest enabled event always wins.

// File: rtl/ecc_event_capture.sv
`timescale 1ns/1ps
module ecc_event_capture #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ATTR_W     = 8,
  parameter int ALIGN_BITS = 3,
  parameter int IDX_W      = 3,
  parameter int REG_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_uncorr,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [ATTR_W-1:0] evt_attr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_FLAGS = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_ADDR  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_ATTR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(4);

  logic [1:0]        enable_q;
  logic [1:0]        flags_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [ATTR_W-1:0] cap_attr_q;
  logic [DATA_W-1:0] cap_data_q;

  wire       take    = evt_valid & enable_q[evt_uncorr];
  wire [1:0] set_vec = take ? (evt_uncorr ? 2'b10 : 2'b01) : 2'b00;
  wire [1:0] clr_vec = (reg_wr && reg_idx == IDX_FLAGS) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 2'b00;
      flags_q  <= 2'b00;
    end else begin
      if (reg_wr && reg_idx == IDX_CTRL)
        enable_q <= reg_wdata[1:0];
      flags_q <= (flags_q & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      cap_addr_q <= {evt_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      cap_attr_q <= evt_attr;
      cap_data_q <= evt_data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_CTRL:  reg_rdata[1:0]        = enable_q;
      IDX_FLAGS: reg_rdata[1:0]        = flags_q;
      IDX_ADDR:  reg_rdata[ADDR_W-1:0] = cap_addr_q;
      IDX_ATTR:  reg_rdata[ATTR_W-1:0] = cap_attr_q;
      IDX_DATA:  reg_rdata[DATA_W-1:0] = cap_data_q;
      default:   reg_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/ecc_event_capture_chk.sv
`timescale 1ns/1ps
module ecc_event_capture_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ATTR_W     = 8,
  parameter int ALIGN_BITS = 3,
  parameter int IDX_W      = 3,
  parameter int REG_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_uncorr,
  input logic [ADDR_W-1:0] evt_addr,
  input logic [ATTR_W-1:0] evt_attr,
  input logic [DATA_W-1:0] evt_data,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [1:0]        enable_q,
  input logic [1:0]        flags_q,
  input logic [ADDR_W-1:0] cap_addr_q,
  input logic [ATTR_W-1:0] cap_attr_q,
  input logic [DATA_W-1:0] cap_data_q
);
  logic seen;
  wire  hit  = evt_valid && enable_q[evt_uncorr];
  wire  miss = evt_valid && !enable_q[evt_uncorr];
  wire  clr_wr = reg_wr && reg_idx == IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (hit) seen <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (enable_q == 2'b00 && flags_q == 2'b00));

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && seen && !clr_wr) |=> ($stable(cap_addr_q) && $stable(cap_attr_q) && $stable(cap_data_q) && $stable(flags_q)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_attr_q == $past(evt_attr) && cap_data_q == $past(evt_data)));

  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_addr_q[ADDR_W-1:ALIGN_BITS] == $past(evt_addr[ADDR_W-1:ALIGN_BITS]) && cap_addr_q[ALIGN_BITS-1:0] == '0));

  p_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flags_q[$past(evt_uncorr)]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[0] && !(clr_wr && reg_wdata[0])) |=> flags_q[0]);

  p_setwins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && evt_uncorr && clr_wr && reg_wdata[1]) |=> flags_q[1]);
endmodule

bind ecc_event_capture ecc_event_capture_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W),
  .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_uncorr(evt_uncorr),
  .evt_addr(evt_addr), .evt_attr(evt_attr), .evt_data(evt_data),
  .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .enable_q(enable_q), .flags_q(flags_q), .cap_addr_q(cap_addr_q),
  .cap_attr_q(cap_attr_q), .cap_data_q(cap_data_q)
);

// File: tb/test_ecc_event_capture.sv
`timescale 1ns/1ps
module test_ecc_event_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_uncorr = 1'b0;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_attr = '0;
  logic [31:0] evt_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  ecc_event_capture i_ecc_event_capture (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_uncorr(evt_uncorr),
    .evt_addr(evt_addr), .evt_attr(evt_attr), .evt_data(evt_data),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  logic [1:0]  m_en = '0, m_flags = '0;
  logic [31:0] m_addr = '0, m_attr = '0, m_data = '0;
  bit          m_seen = 1'b0;

  always @(posedge clk) begin
    logic [1:0] nf, ne;
    if (!rst_n) begin
      m_en = '0;
      m_flags = '0;
    end else begin
      nf = m_flags;
      ne = m_en;
      if (reg_wr && reg_idx == 3'd1) nf = nf & ~reg_wdata[1:0];
      if (reg_wr && reg_idx == 3'd0) ne = reg_wdata[1:0];
      if (evt_valid && m_en[evt_uncorr]) begin
        nf[evt_uncorr] = 1'b1;
        m_addr = evt_addr & 32'hFFFF_FFF8;
        m_attr = {24'b0, evt_attr};
        m_data = evt_data;
        m_seen = 1'b1;
      end
      m_flags = nf;
      m_en = ne;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      case (reg_idx)
        3'd0: check("R9 R1 enables", reg_rdata, {30'b0, m_en});
        3'd1: check("R5 R6 R7 R2 flags", reg_rdata, {30'b0, m_flags});
        3'd2: if (m_seen) check("R4 R8 R2 address", reg_rdata, m_addr);
        3'd3: if (m_seen) check("R3 R8 attributes", reg_rdata, m_attr);
        3'd4: if (m_seen) check("R3 R8 data", reg_rdata, m_data);
        default: check("R10 unmapped", reg_rdata, 32'h0);
      endcase
    end
  end

  task automatic cyc(input bit v, input bit u, input logic [31:0] a, input logic [7:0] at,
                     input logic [31:0] d, input bit w, input logic [2:0] i, input logic [31:0] wd);
    @(negedge clk); #2;
    evt_valid = v; evt_uncorr = u; evt_addr = a; evt_attr = at; evt_data = d;
    reg_wr = w; reg_idx = i; reg_wdata = wd;
    @(posedge clk); #2;
    evt_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] i, input logic [31:0] exp);
    @(negedge clk); #2;
    reg_idx = i;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(20 * 100000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    expect_reg("R1 enables after reset", 3'd0, 32'h0);
    expect_reg("R1 flags after reset", 3'd1, 32'h0);
    expect_reg("R10 index 6 reads zero", 3'd6, 32'h0);

    cyc(1, 0, 32'h1000_0004, 8'h11, 32'hAAAA_0001, 0, 3'd1, 0);
    expect_reg("R2 disabled corrected event leaves flags", 3'd1, 32'h0);

    cyc(0, 0, 0, 0, 0, 1, 3'd0, 32'h1);
    cyc(1, 1, 32'h2000_0000, 8'h22, 32'hBBBB_0002, 0, 3'd1, 0);
    expect_reg("R2 disabled uncorrectable event leaves flags", 3'd1, 32'h0);
    cyc(1, 0, 32'h3000_00FF, 8'h33, 32'hCCCC_0003, 0, 3'd2, 0);
    expect_reg("R5 corrected sets bit 0", 3'd1, 32'h1);
    expect_reg("R4 address aligned", 3'd2, 32'h3000_00F8);
    expect_reg("R3 attributes captured", 3'd3, 32'h33);
    expect_reg("R3 data captured", 3'd4, 32'hCCCC_0003);

    cyc(1, 1, 32'h4444_4447, 8'h44, 32'hDDDD_0004, 0, 3'd2, 0);
    expect_reg("R2 disabled event keeps address", 3'd2, 32'h3000_00F8);

    cyc(0, 0, 0, 0, 0, 1, 3'd0, 32'h3);
    cyc(1, 1, 32'h5555_5557, 8'h55, 32'hEEEE_0005, 0, 3'd1, 0);
    expect_reg("R5 uncorrectable sets bit 1", 3'd1, 32'h3);
    expect_reg("R8 newer event overwrites address", 3'd2, 32'h5555_5550);

    cyc(0, 0, 0, 0, 0, 1, 3'd1, 32'h0);
    expect_reg("R6 writing zero keeps flags", 3'd1, 32'h3);
    cyc(0, 0, 0, 0, 0, 1, 3'd1, 32'h1);
    expect_reg("R6 write one clears bit 0 only", 3'd1, 32'h2);

    cyc(1, 1, 32'h6000_0010, 8'h66, 32'h6666_0006, 1, 3'd1, 32'h2);
    expect_reg("R7 set beats clear", 3'd1, 32'h2);

    cyc(1, 0, 32'h7000_0021, 8'h77, 32'h7777_0007, 1, 3'd0, 32'h0);
    expect_reg("R9 same-cycle event uses old enables", 3'd1, 32'h3);
    expect_reg("R9 enables updated", 3'd0, 32'h0);
    cyc(1, 0, 32'h8000_0000, 8'h88, 32'h8888_0008, 0, 3'd2, 0);
    expect_reg("R9 new enables block event", 3'd2, 32'h7000_0020);

    cyc(0, 0, 0, 0, 0, 1, 3'd2, 32'hFFFF_FFFF);
    expect_reg("R10 write to address index ignored", 3'd2, 32'h7000_0020);
    cyc(0, 0, 0, 0, 0, 1, 3'd7, 32'hFFFF_FFFF);
    expect_reg("R10 index 7 reads zero", 3'd7, 32'h0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom();
      cyc(r[0], r[1], $urandom(), r[15:8], $urandom(), (r[4:2] == 3'd0),
          r[18:16], (r[20:19] == 2'b00) ? {30'b0, r[22:21]} : {30'b0, r[23], 1'b1});
    end

    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule